// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the sequencing core of a vending machine that sells one class of product in a few price grades. It tracks the money a customer has inserted and remembers which product was picked. When a coin arrives after a product has been picked, it decides whether the credit now covers the price. If it does, it releases the product and pays back any surplus. If not, it asks for more coins. Coins are counted before the choice is final, and a shortage sends the customer back to the coin-wait step rather than starting over.

All inputs are sampled on the rising clock edge. Coin and selection arrive as single-cycle pulses that carry a value or a product code. A level-sensitive stock-empty flag takes priority over everything else: the controller refunds every unit of credit it holds, shows an empty message and waits until the flag drops. All outputs come from registers. They are a 3-bit message code for the front-panel display, a one-cycle dispense strobe, a one-cycle refund strobe with the amount to pay back, and the price of the chosen product while a choice is being confirmed.

Top module: `vend_ctrl`

## Requirements
- R1: After a synchronous reset the message code is 0, both strobes are low, the refund amount is 0, the shown price is 0 and the held credit is 0.
- R2: In the idle state a coin pulse adds its value to credit, moves to the coin-wait state and sets message code 1 (select product). A selection pulse in idle has no effect and the message stays 0.
- R3: In the coin-wait state a selection pulse latches the product code, moves to the confirm state, sets message code 2 (confirm price) and shows that product's price. With default parameters the prices for codes 0, 1, 2 and 3 are 25, 50, 75 and 100.
- R4: In the confirm state a coin triggers the check. If credit plus coin is at least the price, the dispense strobe pulses in the next cycle. When the total exceeds the price, the refund strobe pulses in that same cycle with amount equal to the total minus the price. An exact total gives no refund strobe and an amount of 0.
- R5: When the check fails, the controller keeps the enlarged credit, returns to coin-wait and sets message code 3 (insert more coins).
- R6: In the dispensing state coins are ignored, and the message code keeps its value from the confirm step. The return-done acknowledge moves the controller to idle with message code 0 and zero credit.
- R7: An out-of-stock flag seen in any state other than the stock-empty state moves the controller there, sets message code 4 and pulses the refund strobe once. The refund amount is all held credit plus any coin arriving in that cycle. While the flag stays high, no further refund is made.
- R8: In the stock-empty state, the cycle the flag is sampled low moves the controller to idle with message code 0 and zero credit.
- R9: When a coin and a selection arrive in the same cycle in coin-wait, the coin is credited before the choice is taken.
- R10: Credit saturates at the all-ones value (255 by default) and does not wrap.
- R11: The message code changes only on state transitions. A coin that keeps the controller in coin-wait leaves the code unchanged.
- R12: The dispense strobe and the refund strobe are each high for exactly one cycle per event. The refund amount is 0 whenever the refund strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_pulse | input | 1 | One-cycle pulse: a coin was accepted |
| coin_value | input | CREDIT_W | Value of the accepted coin |
| sel_pulse | input | 1 | One-cycle pulse: a product button was pressed |
| sel_code | input | CODE_W | Product code of the pressed button |
| out_of_stock | input | 1 | Stock-empty level flag, highest priority |
| change_ack | input | 1 | Pay-back mechanism reports it has finished |
| disp_code | output | 3 | Message code: 0 idle, 1 select, 2 confirm, 3 more coins, 4 empty |
| dispense_pulse | output | 1 | One-cycle release strobe |
| refund_pulse | output | 1 | One-cycle pay-back strobe |
| change_amt | output | CREDIT_W | Amount to pay back, valid with refund_pulse |
| shown_price | output | CREDIT_W | Price of the chosen product while confirming, else 0 |

## Verification
The bench targets a check that lands exactly on the price, where a design comparing with strict greater-than would refuse the sale or would pulse a refund of zero. It checks that credit survives a failed check and that a coin arriving with a selection is counted. A design that dropped the coin would show the insert-more message instead of dispensing. A stock-empty event arrives together with a coin: a design that ignored that coin would refund too little, and one that refunded on every flagged cycle would pulse again. Two large coins drive credit into saturation, where a wrapping adder would pay back a visibly wrong amount. A coin dropped during dispensing must not leak into the next sale's change.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int MSG_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_COIN = 3'd1,
        ST_SEL  = 3'd2,
        ST_DISP = 3'd3,
        ST_OOS  = 3'd4
    } vend_state_e;

    typedef enum logic [MSG_W-1:0] {
        MSG_IDLE    = 3'd0,
        MSG_SELECT  = 3'd1,
        MSG_CONFIRM = 3'd2,
        MSG_MORE    = 3'd3,
        MSG_EMPTY   = 3'd4
    } msg_e;

    typedef enum logic [1:0] {
        CR_HOLD  = 2'd0,
        CR_ADD   = 2'd1,
        CR_CLEAR = 2'd2
    } credit_op_e;

    typedef struct packed {
        vend_state_e state;
        msg_e        msg;
        logic        dispense;
        logic        refund;
    } ctrl_regs_t;

    function automatic logic is_busy_state(input vend_state_e s);
        return (s == ST_DISP) || (s == ST_OOS);
    endfunction

endpackage

// File: rtl/vend_price_rom.sv
module vend_price_rom #(
    parameter int CODE_W   = 2,
    parameter int PRICE_W  = 8,
    parameter int NUM_PROD = 2 ** CODE_W,
    parameter logic [NUM_PROD*PRICE_W-1:0] PRICE_TABLE = '0
) (
    input  logic [CODE_W-1:0]  code,
    output logic [PRICE_W-1:0] price
);
    logic [PRICE_W-1:0] grade [NUM_PROD];

    for (genvar g = 0; g < NUM_PROD; g++) begin : g_grade
        assign grade[g] = PRICE_TABLE[g*PRICE_W +: PRICE_W];
    end

    assign price = grade[code];
endmodule

// File: rtl/vend_credit.sv
module vend_credit
    import vend_pkg::*;
#(
    parameter int CREDIT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  credit_op_e          op,
    input  logic [CREDIT_W-1:0] add_val,
    output logic [CREDIT_W-1:0] credit,
    output logic [CREDIT_W-1:0] sum
);
    localparam logic [CREDIT_W-1:0] CREDIT_MAX = '1;

    logic [CREDIT_W:0]   wide;
    logic [CREDIT_W-1:0] credit_q;

    assign wide = {1'b0, credit_q} + {1'b0, add_val};
    assign sum  = wide[CREDIT_W] ? CREDIT_MAX : wide[CREDIT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= '0;
        end else begin
            unique case (op)
                CR_ADD:   credit_q <= sum;
                CR_CLEAR: credit_q <= '0;
                default:  credit_q <= credit_q;
            endcase
        end
    end

    assign credit = credit_q;
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
#(
    parameter int CREDIT_W = 8,
    parameter int CODE_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_pulse,
    input  logic                sel_pulse,
    input  logic [CODE_W-1:0]   sel_code,
    input  logic                out_of_stock,
    input  logic                change_ack,
    input  logic [CREDIT_W-1:0] sum,
    input  logic [CREDIT_W-1:0] price,
    output vend_state_e         state_q,
    output logic [CODE_W-1:0]   sel_q,
    output msg_e                msg_q,
    output logic                dispense_q,
    output logic                refund_q,
    output logic [CREDIT_W-1:0] change_q,
    output credit_op_e          cr_op
);
    ctrl_regs_t          cur, nxt;
    logic [CODE_W-1:0]   sel_n;
    logic [CREDIT_W-1:0] change_n;

    assign cur.state    = state_q;
    assign cur.msg      = msg_q;
    assign cur.dispense = dispense_q;
    assign cur.refund   = refund_q;

    always_comb begin
        nxt          = cur;
        nxt.dispense = 1'b0;
        nxt.refund   = 1'b0;
        change_n     = '0;
        sel_n        = sel_q;
        cr_op        = CR_HOLD;
        if (out_of_stock && (cur.state != ST_OOS)) begin
            nxt.state  = ST_OOS;
            nxt.msg    = MSG_EMPTY;
            nxt.refund = 1'b1;
            change_n   = sum;
            cr_op      = CR_CLEAR;
        end else begin
            unique case (cur.state)
                ST_IDLE: begin
                    if (coin_pulse) begin
                        nxt.state = ST_COIN;
                        nxt.msg   = MSG_SELECT;
                        cr_op     = CR_ADD;
                    end
                end
                ST_COIN: begin
                    if (coin_pulse) begin
                        cr_op = CR_ADD;
                    end
                    if (sel_pulse) begin
                        nxt.state = ST_SEL;
                        nxt.msg   = MSG_CONFIRM;
                        sel_n     = sel_code;
                    end
                end
                ST_SEL: begin
                    if (coin_pulse) begin
                        if (sum >= price) begin
                            nxt.state    = ST_DISP;
                            nxt.dispense = 1'b1;
                            cr_op        = CR_CLEAR;
                            if (sum > price) begin
                                nxt.refund = 1'b1;
                                change_n   = sum - price;
                            end
                        end else begin
                            nxt.state = ST_COIN;
                            nxt.msg   = MSG_MORE;
                            cr_op     = CR_ADD;
                        end
                    end
                end
                ST_DISP: begin
                    if (change_ack) begin
                        nxt.state = ST_IDLE;
                        nxt.msg   = MSG_IDLE;
                        cr_op     = CR_CLEAR;
                    end
                end
                ST_OOS: begin
                    if (!out_of_stock) begin
                        nxt.state = ST_IDLE;
                        nxt.msg   = MSG_IDLE;
                        cr_op     = CR_CLEAR;
                    end
                end
                default: begin
                    nxt.state = ST_IDLE;
                    nxt.msg   = MSG_IDLE;
                    cr_op     = CR_CLEAR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            msg_q      <= MSG_IDLE;
            dispense_q <= 1'b0;
            refund_q   <= 1'b0;
            change_q   <= '0;
            sel_q      <= '0;
        end else begin
            state_q    <= nxt.state;
            msg_q      <= nxt.msg;
            dispense_q <= nxt.dispense;
            refund_q   <= nxt.refund;
            change_q   <= change_n;
            sel_q      <= sel_n;
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int CREDIT_W = 8,
    parameter int CODE_W   = 2,
    parameter logic [(2**CODE_W)*CREDIT_W-1:0] PRICE_TABLE =
        {8'd100, 8'd75, 8'd50, 8'd25}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_pulse,
    input  logic [CREDIT_W-1:0] coin_value,
    input  logic                sel_pulse,
    input  logic [CODE_W-1:0]   sel_code,
    input  logic                out_of_stock,
    input  logic                change_ack,
    output logic [2:0]          disp_code,
    output logic                dispense_pulse,
    output logic                refund_pulse,
    output logic [CREDIT_W-1:0] change_amt,
    output logic [CREDIT_W-1:0] shown_price
);
    localparam int NUM_PROD = 2 ** CODE_W;

    vend_state_e         state_q;
    msg_e                msg_q;
    credit_op_e          cr_op;
    logic [CODE_W-1:0]   sel_q;
    logic [CREDIT_W-1:0] credit, sum, price, add_val;

    assign add_val = coin_pulse ? coin_value : '0;

    vend_price_rom #(
        .CODE_W     (CODE_W),
        .PRICE_W    (CREDIT_W),
        .NUM_PROD   (NUM_PROD),
        .PRICE_TABLE(PRICE_TABLE)
    ) u_rom (
        .code (sel_q),
        .price(price)
    );

    vend_credit #(.CREDIT_W(CREDIT_W)) u_credit (
        .clk    (clk),
        .rst    (rst),
        .op     (cr_op),
        .add_val(add_val),
        .credit (credit),
        .sum    (sum)
    );

    vend_fsm #(.CREDIT_W(CREDIT_W), .CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .coin_pulse  (coin_pulse),
        .sel_pulse   (sel_pulse),
        .sel_code    (sel_code),
        .out_of_stock(out_of_stock),
        .change_ack  (change_ack),
        .sum         (sum),
        .price       (price),
        .state_q     (state_q),
        .sel_q       (sel_q),
        .msg_q       (msg_q),
        .dispense_q  (dispense_pulse),
        .refund_q    (refund_pulse),
        .change_q    (change_amt),
        .cr_op       (cr_op)
    );

    assign disp_code   = msg_q;
    assign shown_price = (state_q == ST_SEL) ? price : '0;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
#(
    parameter int CREDIT_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                out_of_stock,
    input logic                change_ack,
    input logic [2:0]          disp_code,
    input logic                dispense_pulse,
    input logic                refund_pulse,
    input logic [CREDIT_W-1:0] change_amt,
    input vend_state_e         state
);
    // R7: the empty state always shows the empty message
    p_empty_msg_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OOS) |-> (disp_code == 3'd4));

    // R7: a flag seen outside the empty state enters it with a refund
    p_empty_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (out_of_stock && state != ST_OOS) |=> (state == ST_OOS && refund_pulse));

    // R7: a held flag in the empty state never refunds again
    p_no_second_refund_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OOS && out_of_stock) |=> !refund_pulse);

    // R8: leaving the empty state lands in idle with the idle message
    p_empty_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OOS && !out_of_stock) |=> (state == ST_IDLE && disp_code == 3'd0));

    // R6: acknowledge in the dispensing state returns to idle
    p_ack_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DISP && change_ack && !out_of_stock) |=> (state == ST_IDLE && disp_code == 3'd0));

    // R4: the release strobe only accompanies the dispensing state
    p_dispense_state_r4: assert property (@(posedge clk) disable iff (rst)
        dispense_pulse |-> (state == ST_DISP));

    // R12: release strobe lasts one cycle
    p_dispense_once_r12: assert property (@(posedge clk) disable iff (rst)
        dispense_pulse |=> !dispense_pulse);

    // R12: no pay-back amount without the strobe
    p_amt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !refund_pulse |-> (change_amt == '0));

    // R11: message codes stay within the defined set
    p_msg_legal_r11: assert property (@(posedge clk) disable iff (rst)
        disp_code <= 3'd4);

    // R11: the message only moves when the state moves
    p_msg_on_move_r11: assert property (@(posedge clk) disable iff (rst)
        $stable(state) |-> $stable(disp_code));
endmodule

bind vend_ctrl vend_ctrl_chk #(.CREDIT_W(CREDIT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .out_of_stock  (out_of_stock),
    .change_ack    (change_ack),
    .disp_code     (disp_code),
    .dispense_pulse(dispense_pulse),
    .refund_pulse  (refund_pulse),
    .change_amt    (change_amt),
    .state         (state_q)
);

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          coin_pulse = 1'b0;
    logic [W-1:0]  coin_value = '0;
    logic          sel_pulse = 1'b0;
    logic [CW-1:0] sel_code = '0;
    logic          out_of_stock = 1'b0;
    logic          change_ack = 1'b0;
    logic [2:0]    disp_code;
    logic          dispense_pulse, refund_pulse;
    logic [W-1:0]  change_amt, shown_price;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_ctrl u_vend_ctrl (
        .clk(clk), .rst(rst),
        .coin_pulse(coin_pulse), .coin_value(coin_value),
        .sel_pulse(sel_pulse), .sel_code(sel_code),
        .out_of_stock(out_of_stock), .change_ack(change_ack),
        .disp_code(disp_code), .dispense_pulse(dispense_pulse),
        .refund_pulse(refund_pulse), .change_amt(change_amt),
        .shown_price(shown_price)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    // drive one cycle of inputs; returns at the following falling edge
    task automatic cyc(input bit coin, input int val, input bit sel, input int code,
                       input bit oos, input bit ack);
        coin_pulse   = coin;
        coin_value   = W'(val);
        sel_pulse    = sel;
        sel_code     = CW'(code);
        out_of_stock = oos;
        change_ack   = ack;
        @(negedge clk);
    endtask

    task automatic quiet();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 msg", disp_code, 0);
        chk("R1 dispense", dispense_pulse, 0);
        chk("R1 refund", refund_pulse, 0);
        chk("R1 amount", change_amt, 0);
        chk("R1 price", shown_price, 0);
    endtask

    task automatic t_exact_sale();
        cyc(0, 0, 1, 1, 0, 0);
        chk("R2 select ignored in idle", disp_code, 0);
        cyc(1, 25, 0, 0, 0, 0);
        chk("R2 coin in idle", disp_code, 1);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R11 msg held on coin", disp_code, 1);
        cyc(0, 0, 1, 1, 0, 0);
        chk("R3 confirm msg", disp_code, 2);
        chk("R3 shown price", shown_price, 50);
        cyc(1, 25, 0, 0, 0, 0);
        chk("R4 exact dispense", dispense_pulse, 1);
        chk("R4 exact no refund", refund_pulse, 0);
        chk("R4 exact amount", change_amt, 0);
        quiet();
        chk("R12 dispense one cycle", dispense_pulse, 0);
        chk("R6 msg kept while dispensing", disp_code, 2);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R6 ack to idle", disp_code, 0);
        quiet();
    endtask

    task automatic t_short_then_change();
        cyc(1, 25, 0, 0, 0, 0);
        cyc(0, 0, 1, 3, 0, 0);
        chk("R3 price code 3", shown_price, 100);
        cyc(1, 25, 0, 0, 0, 0);
        chk("R5 more coins msg", disp_code, 3);
        chk("R5 no dispense", dispense_pulse, 0);
        cyc(0, 0, 1, 3, 0, 0);
        chk("R5 reconfirm", disp_code, 2);
        cyc(1, 100, 0, 0, 0, 0);
        chk("R4 dispense with change", dispense_pulse, 1);
        chk("R4 refund strobe", refund_pulse, 1);
        chk("R5 credit kept, change", change_amt, 50);
        quiet();
        chk("R12 refund one cycle", refund_pulse, 0);
        chk("R12 amount cleared", change_amt, 0);
        cyc(1, 50, 0, 0, 0, 0);
        chk("R6 coin ignored msg", disp_code, 2);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R6 ack idle", disp_code, 0);
        cyc(1, 25, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0);
        cyc(1, 25, 0, 0, 0, 0);
        chk("R6 coin in dispensing not credited", refund_pulse, 0);
        chk("R6 fresh sale dispenses", dispense_pulse, 1);
        cyc(0, 0, 0, 0, 0, 1);
        quiet();
    endtask

    task automatic t_coin_with_select();
        cyc(1, 25, 0, 0, 0, 0);
        cyc(1, 25, 1, 1, 0, 0);
        chk("R9 confirm msg", disp_code, 2);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R9 coin counted, dispense", dispense_pulse, 1);
        chk("R9 msg not more-coins", disp_code, 2);
        cyc(0, 0, 0, 0, 0, 1);
        quiet();
    endtask

    task automatic t_empty();
        cyc(1, 50, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 10, 0, 0, 1, 0);
        chk("R7 empty msg", disp_code, 4);
        chk("R7 refund strobe", refund_pulse, 1);
        chk("R7 refund all credit", change_amt, 60);
        chk("R7 no dispense", dispense_pulse, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7 single refund", refund_pulse, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7 msg held", disp_code, 4);
        quiet();
        chk("R8 idle after flag drops", disp_code, 0);
        cyc(1, 25, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0);
        cyc(1, 25, 0, 0, 0, 0);
        chk("R8 credit cleared", refund_pulse, 0);
        chk("R8 fresh sale", dispense_pulse, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7 idle refund strobe", refund_pulse, 1);
        chk("R7 idle refund zero", change_amt, 0);
        quiet();
        chk("R8 idle again", disp_code, 0);
    endtask

    task automatic t_saturate();
        cyc(1, 200, 0, 0, 0, 0);
        cyc(1, 200, 0, 0, 0, 0);
        cyc(0, 0, 1, 3, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R10 dispense", dispense_pulse, 1);
        chk("R10 saturated change", change_amt, 155);
        cyc(0, 0, 0, 0, 0, 1);
        quiet();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exact_sale();
        t_short_then_change();
        t_coin_with_select();
        t_empty();
        t_saturate();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule